// File: doc/BRIEF.md
# MDIO Management Command Controller

This block lets software reach the management registers of an external Ethernet PHY through one 32-bit command word. A single store carries the PHY address, the register number, the direction and, for a write, the 16 data bits. The controller then clocks out a complete clause-22 management frame on MDC/MDIO. For a read, the PHY's reply lands in the low half of the same word. Two flags in that word report progress: a busy flag that stays high for the whole frame, and a read-valid flag that appears only once read data has been captured.

A second register holds the controller's own 5-bit PHY address. Software polls busy before issuing each command. A command stored while a frame is still running is discarded as a whole. MDC runs only during a frame, at the system clock divided by `DIV`. MDIO changes on MDC falling edges, and the PHY's reply is sampled on rising edges.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: The command register at word offset `CMD_OFS` (default 0) holds data in bits 15:0, PHY address in 20:16, register number in 25:21 and direction in bit 26 (0 = write, 1 = read). It reads back the accepted command; after a write command the data field shows the written data, and during a read it shows 0.
- R2: Busy (bit 28) reads 1 from the clock edge that accepts a command until exactly 64*DIV clock cycles later, then reads 0.
- R3: A store to the command register while busy is 1 changes no field of the register and starts no extra frame.
- R4: MDC is low whenever no frame runs; during a frame its period is DIV system clocks, with DIV/2 cycles high.
- R5: A write frame is, MSB first: 32 ones, start 01, opcode 01, 5-bit PHY address, 5-bit register number, turnaround 10, then the 16 data bits.
- R6: A read frame uses opcode 10. The controller drives MDIO (mdio_oe = 1) for the first 46 bits and releases it (mdio_oe = 0) for the turnaround and the 16 data bits.
- R7: Read-valid (bit 27) is 0 while busy and after any write command. It becomes 1 when a read frame completes, together with the 16 bits sampled on the last 16 MDC rising edges in data bits 15:0.
- R8: Accepting a new command clears read-valid.
- R9: The PHY-address register at word offset `PADR_OFS` (default 1) keeps bits 4:0 of a store; its bits 31:5 always read 0.
- R10: After reset both registers read 0, MDC is 0, mdio_oe is 0 and mdio_o is 1.
- R11: During a frame, mdio_o changes only on clock edges where MDC falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register store strobe, one cycle per store |
| bus_addr | input | ADDR_W | Register word offset |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Read data of the register at bus_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data from the PHY |

## Verification
The bench builds the controller with DIV = 8 and ADDR_W = 2. A full 64-bit frame therefore takes 512 clocks, so several write and read frames fit in a short run. The exact busy window of 64*DIV cycles is measured to the cycle. The low divider makes the half-period sampling point of every bit reachable, so MDIO stability between edges can be checked bit by bit. With ADDR_W = 2 the bench can also show that the offsets other than the two registers read as zero.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   localparam int FRAME_BITS = 64;
   localparam int PRE_BITS   = 32;
   // bit index (from frame start) where a read releases the line
   localparam int TA_IDX     = 46;
   localparam int DATA_IDX   = 48;

   // command word bit positions
   localparam int OP_BIT   = 26;
   localparam int RDV_BIT  = 27;
   localparam int BUSY_BIT = 28;
   localparam int PHY_LSB  = 16;
   localparam int REG_LSB  = 21;

   typedef struct packed {
      logic        op_rd;
      logic        rdv;
      logic [4:0]  regad;
      logic [4:0]  phyad;
      logic [15:0] data;
   } cmd_t;

   function automatic logic [FRAME_BITS-1:0] make_frame(
      input logic        rd,
      input logic [4:0]  pa,
      input logic [4:0]  ra,
      input logic [15:0] d);
      logic [1:0] opc;
      opc = rd ? 2'b10 : 2'b01;
      return {{PRE_BITS{1'b1}}, 2'b01, opc, pa, ra, 2'b10, (rd ? 16'h0000 : d)};
   endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int DIV = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_stb,
   output logic fall_stb
);
   localparam int CW   = $clog2(DIV);
   localparam int HALF = DIV / 2;
   localparam logic [CW-1:0] LAST  = CW'(DIV - 1);
   localparam logic [CW-1:0] HLAST = CW'(HALF - 1);

   logic [CW-1:0] cnt;

   assign rise_stb = run && (cnt == HLAST);
   assign fall_stb = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else begin
         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
         if (rise_stb)
            mdc <= 1'b1;
         else if (fall_stb)
            mdc <= 1'b0;
      end
   end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
   import mdio_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  is_read,
   input  logic [FRAME_BITS-1:0] frame,
   input  logic                  rise_stb,
   input  logic                  fall_stb,
   input  logic                  mdio_i,
   output logic                  mdio_o,
   output logic                  mdio_oe,
   output logic                  active,
   output logic                  done,
   output logic [15:0]           rd_data
);
   localparam int IW = $clog2(FRAME_BITS);
   localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);
   localparam logic [IW-1:0] REL_IDX  = IW'(TA_IDX);
   localparam logic [IW-1:0] CAP_IDX  = IW'(DATA_IDX);

   logic [FRAME_BITS-1:0] shreg;
   logic [IW-1:0]         idx;
   logic                  rd_q;

   assign done    = active && fall_stb && (idx == LAST_IDX);
   assign mdio_o  = active ? shreg[FRAME_BITS-1] : 1'b1;
   assign mdio_oe = active && !(rd_q && (idx >= REL_IDX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         idx     <= '0;
         rd_q    <= 1'b0;
         active  <= 1'b0;
         rd_data <= '0;
      end else begin
         if (start) begin
            shreg  <= frame;
            idx    <= '0;
            rd_q   <= is_read;
            active <= 1'b1;
         end else if (active && fall_stb) begin
            if (idx == LAST_IDX) begin
               active <= 1'b0;
            end else begin
               idx   <= idx + 1'b1;
               shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
            end
         end
         if (active && rise_stb && rd_q && (idx >= CAP_IDX))
            rd_data <= {rd_data[14:0], mdio_i};
      end
   end
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
   import mdio_pkg::*;
#(
   parameter int DIV      = 64,
   parameter int ADDR_W   = 2,
   parameter int CMD_OFS  = 0,
   parameter int PADR_OFS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_OFS);
   localparam logic [ADDR_W-1:0] PADR_A = ADDR_W'(PADR_OFS);

   generate
      if (DIV < 4 || (DIV % 2) != 0) begin : g_bad_div
         $error("DIV must be even and at least 4");
      end
      if (ADDR_W < 1 || CMD_OFS == PADR_OFS ||
          CMD_OFS >= (1 << ADDR_W) || PADR_OFS >= (1 << ADDR_W)) begin : g_bad_map
         $error("register offsets must be distinct and fit in ADDR_W");
      end
   endgenerate

   cmd_t       cmd_q;
   logic [4:0] own_phy;
   logic       busy;
   logic       start;
   logic       done;
   logic       rise_stb;
   logic       fall_stb;
   logic [15:0] rx_data;
   logic [FRAME_BITS-1:0] frame;

   assign start = bus_we && (bus_addr == CMD_A) && !busy;
   assign frame = make_frame(bus_wdata[OP_BIT],
                             bus_wdata[PHY_LSB +: 5],
                             bus_wdata[REG_LSB +: 5],
                             bus_wdata[15:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (start) begin
         cmd_q.op_rd <= bus_wdata[OP_BIT];
         cmd_q.rdv   <= 1'b0;
         cmd_q.regad <= bus_wdata[REG_LSB +: 5];
         cmd_q.phyad <= bus_wdata[PHY_LSB +: 5];
         cmd_q.data  <= bus_wdata[OP_BIT] ? 16'h0000 : bus_wdata[15:0];
      end else if (done && cmd_q.op_rd) begin
         cmd_q.rdv  <= 1'b1;
         cmd_q.data <= rx_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         own_phy <= '0;
      else if (bus_we && bus_addr == PADR_A)
         own_phy <= bus_wdata[4:0];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == CMD_A) begin
         bus_rdata[BUSY_BIT]         = busy;
         bus_rdata[RDV_BIT]          = cmd_q.rdv;
         bus_rdata[OP_BIT]           = cmd_q.op_rd;
         bus_rdata[REG_LSB +: 5]     = cmd_q.regad;
         bus_rdata[PHY_LSB +: 5]     = cmd_q.phyad;
         bus_rdata[15:0]             = cmd_q.data;
      end else if (bus_addr == PADR_A) begin
         bus_rdata[4:0] = own_phy;
      end
   end

   mdio_mdc_gen #(.DIV(DIV)) u_mdc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .mdc      (mdc),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   mdio_frame_shifter u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .is_read  (bus_wdata[OP_BIT]),
      .frame    (frame),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb),
      .mdio_i   (mdio_i),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .active   (busy),
      .done     (done),
      .rd_data  (rx_data)
   );
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk #(
   parameter int ADDR_W   = 2,
   parameter int CMD_OFS  = 0,
   parameter int PADR_OFS = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_rdata,
   input logic              mdc,
   input logic              mdio_o,
   input logic              mdio_oe,
   input logic              busy,
   input logic              rdv,
   input logic [4:0]        cmd_phy,
   input logic [4:0]        cmd_reg
);
   localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_OFS);
   localparam logic [ADDR_W-1:0] PADR_A = ADDR_W'(PADR_OFS);

   // R4
   mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   // R6
   oe_inside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> busy);

   // R7
   rdv_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !rdv);

   // R3
   busy_store_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_we && bus_addr == CMD_A) |=> ($stable(cmd_phy) && $stable(cmd_reg)));

   // R11
   mdio_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

   // R9
   padr_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == PADR_A) |-> (bus_rdata[31:5] == 27'd0));
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk #(
   .ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS), .PADR_OFS(PADR_OFS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .mdc       (mdc),
   .mdio_o    (mdio_o),
   .mdio_oe   (mdio_oe),
   .busy      (busy),
   .rdv       (cmd_q.rdv),
   .cmd_phy   (cmd_q.phyad),
   .cmd_reg   (cmd_q.regad)
);

// File: tb/mdio_cmd_ctrl_bench.sv
module mdio_cmd_ctrl_bench;
   localparam int CLK_P  = 10;
   localparam int DIV    = 8;
   localparam int ADDR_W = 2;
   localparam int FRAME_CYC = 64 * DIV;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_we = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              mdc, mdio_o, mdio_oe;
   logic              mdio_i = 1'b1;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int acc_cyc = 0;
   int frames_done = 0;
   int mdc_rises = 0;
   bit finished = 0;

   logic [63:0] exp_q[$];
   bit          rd_q[$];
   logic [15:0] phy_data = '0;

   mdio_cmd_ctrl #(.DIV(DIV), .ADDR_W(ADDR_W), .CMD_OFS(0), .PADR_OFS(1)) u_mdio_cmd_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(posedge mdc) mdc_rises <= mdc_rises + 1;

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   function automatic logic [31:0] cmd_word(input bit busy, input bit rdv, input bit rd,
                                            input logic [4:0] ra, input logic [4:0] pa,
                                            input logic [15:0] d);
      return {3'b000, busy, rdv, rd, ra, pa, d};
   endfunction

   function automatic logic [63:0] line_of(input bit rd, input logic [4:0] pa,
                                           input logic [4:0] ra, input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, d};
   endfunction

   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   // driver: pushes the expected frame, then issues the command
   task automatic start_cmd(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                            input logic [15:0] d);
      exp_q.push_back(line_of(rd, pa, ra, rd ? phy_data : d));
      rd_q.push_back(rd);
      bus_write(2'd0, {5'b0, rd, ra, pa, d});
      acc_cyc = cyc;
   endtask

   task automatic wait_done();
      while (cyc < acc_cyc + FRAME_CYC - 1) @(negedge clk);
      check(u_mdio_cmd_ctrl.bus_rdata[28] === 1'b1 || bus_addr != 0, "R2 busy before end", 0, 1);
      bus_addr = 2'd0;
      #1 check(bus_rdata[28] === 1'b1, "R2 busy at last frame cycle", bus_rdata[28], 1);
      @(negedge clk);
      #1 check(bus_rdata[28] === 1'b0, "R2 busy clear after 64*DIV", bus_rdata[28], 0);
   endtask

   // monitor: acts as PHY and compares each frame with the queue head
   initial begin
      forever begin
         logic [63:0] line, got;
         bit rd;
         int oe_bad, stab_bad;
         logic s, so;
         wait (exp_q.size() > 0);
         line = exp_q[0]; rd = rd_q[0];
         got = '0; oe_bad = 0; stab_bad = 0;
         mdio_i = line[63];
         for (int i = 0; i < 64; i++) begin
            @(posedge mdc);
            so = mdio_o;
            s = mdio_oe ? mdio_o : mdio_i;
            got = {got[62:0], s};
            if (mdio_oe !== !(rd && i >= 46)) oe_bad++;
            #((DIV/2 - 1) * CLK_P + CLK_P/2);
            if (mdio_o !== so) stab_bad++;
            @(negedge mdc);
            if (i < 63) mdio_i = line[62 - i];
         end
         void'(exp_q.pop_front());
         void'(rd_q.pop_front());
         mdio_i = 1'b1;
         if (rd) begin
            check(got === line, "R6 read frame bits", got, line);
            check(oe_bad == 0, "R6 line release", oe_bad, 0);
         end else begin
            check(got === line, "R5 write frame bits", got, line);
         end
         check(stab_bad == 0, "R11 mdio stable between falling edges", stab_bad, 0);
         frames_done++;
      end
   end

   initial begin
      #(CLK_P * 200000);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
   end

   initial begin
      logic [31:0] v;
      time t0, t1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      bus_read(2'd0, v); check(v === 32'h0, "R10 command reg reset", v, 0);
      bus_read(2'd1, v); check(v === 32'h0, "R10 phy addr reg reset", v, 0);
      check(mdc === 1'b0 && mdio_oe === 1'b0 && mdio_o === 1'b1, "R10 line idle",
            {mdc, mdio_oe, mdio_o}, 3'b001);

      // R9 own PHY address register
      bus_write(2'd1, 32'hFFFF_FFF5);
      bus_read(2'd1, v); check(v === 32'h15, "R9 keeps bits 4:0 only", v, 32'h15);
      bus_write(2'd1, 32'h0000_000A);
      bus_read(2'd1, v); check(v === 32'h0A, "R9 rewrite", v, 32'h0A);
      bus_read(2'd3, v); check(v === 32'h0, "R9 unused offset reads 0", v, 0);

      // write command
      start_cmd(1'b0, 5'd5, 5'd26, 16'hBEEF);
      bus_read(2'd0, v);
      check(v === cmd_word(1, 0, 0, 5'd26, 5'd5, 16'hBEEF), "R1 R2 write cmd readback busy", v,
            cmd_word(1, 0, 0, 5'd26, 5'd5, 16'hBEEF));
      // R3 store while busy is dropped
      bus_write(2'd0, {5'b0, 1'b1, 5'd3, 5'd9, 16'h1234});
      bus_read(2'd0, v);
      check(v === cmd_word(1, 0, 0, 5'd26, 5'd5, 16'hBEEF), "R3 busy store ignored", v,
            cmd_word(1, 0, 0, 5'd26, 5'd5, 16'hBEEF));
      // R4 MDC period and duty
      @(posedge mdc); t0 = $time;
      @(negedge mdc); t1 = $time;
      check((t1 - t0) == (DIV/2) * CLK_P, "R4 mdc high time", t1 - t0, (DIV/2) * CLK_P);
      @(posedge mdc);
      check(($time - t0) == DIV * CLK_P, "R4 mdc period", $time - t0, DIV * CLK_P);
      wait_done();
      bus_read(2'd0, v);
      check(v === cmd_word(0, 0, 0, 5'd26, 5'd5, 16'hBEEF), "R7 write leaves valid low", v,
            cmd_word(0, 0, 0, 5'd26, 5'd5, 16'hBEEF));
      wait (frames_done == 1);
      check(mdc === 1'b0, "R4 mdc low when idle", mdc, 0);

      // read command
      phy_data = 16'hA53C;
      start_cmd(1'b1, 5'd31, 5'd0, 16'hFFFF);
      bus_read(2'd0, v);
      check(v === cmd_word(1, 0, 1, 5'd0, 5'd31, 16'h0), "R7 R1 read in flight", v,
            cmd_word(1, 0, 1, 5'd0, 5'd31, 16'h0));
      wait_done();
      bus_read(2'd0, v);
      check(v === cmd_word(0, 1, 1, 5'd0, 5'd31, 16'hA53C), "R7 read data valid", v,
            cmd_word(0, 1, 1, 5'd0, 5'd31, 16'hA53C));
      wait (frames_done == 2);

      // R8 new command clears read-valid
      start_cmd(1'b0, 5'd0, 5'd31, 16'h0001);
      bus_read(2'd0, v);
      check(v[27] === 1'b0, "R8 valid cleared by new command", v[27], 0);
      wait_done();
      wait (frames_done == 3);

      // second read, edge data pattern
      phy_data = 16'h8001;
      start_cmd(1'b1, 5'd17, 5'd3, 16'h0);
      wait_done();
      bus_read(2'd0, v);
      check(v === cmd_word(0, 1, 1, 5'd3, 5'd17, 16'h8001), "R7 second read data", v,
            cmd_word(0, 1, 1, 5'd3, 5'd17, 16'h8001));
      wait (frames_done == 4);
      repeat (4 * DIV) @(negedge clk);
      check(mdc_rises == 4 * 64, "R3 no extra frame started", mdc_rises, 4 * 64);
      check(mdio_oe === 1'b0 && mdio_o === 1'b1, "R10 line idle after frames",
            {mdio_oe, mdio_o}, 2'b01);
      report();
   end
endmodule